// File: doc/BRIEF.md
# PLL Loop-Filter Qualification Sweep

This controller picks a loop-filter setting for a clock synthesiser whose multiplier, divider and post-divider values are already known. It runs a sequence of lock trials. Each trial loads one set of M, N and P values into the PLL. It waits a bounded number of time ticks for the lock indication, then counts how many ticks show lock over a fixed sampling window. A trial passes only when that count reaches a threshold. The 3-bit filter field of P is stepped through all eight positions, starting from zero.

A filter position is optimal when the requested N and the six divider values around it (three below, three above) all pass. The sweep stops at the first optimal position. A position where N passes but a neighbour fails is kept as a backup, and a later backup replaces an earlier one. If no position qualifies at all, the original P is returned with an error flag. The PLL is held disabled for the whole sweep. All timing uses a tick input, normally one pulse per microsecond. The lock input is asynchronous and passes through a two-flop synchroniser.

Top module: `pll_filter_sweep`

## Requirements
- R1: After reset, `done`, `pll_prog`, `pll_disable`, `err`, `quality` and `p_out` are all zero.
- R2: A trial fails when the synchronised lock input shows no lock on any of `WAIT_TICKS` consecutive ticks.
- R3: Once lock has been seen, the trial samples lock on `SAMPLE_TICKS` further ticks. It passes if and only if at least `PASS_MIN` samples show lock.
- R4: The first trial of a sweep uses `p_in & KEEP_MASK` (default 0x47, so bits 5:3 and bit 7 are cleared). Each new filter position adds 8 to P, for 8 positions in total.
- R5: When a centre trial passes, trials follow with N-3, N-2, N-1, N+1, N+2 and N+3, in that order and modulo 2^N_W. The sequence stops at the first failure. If all six pass, the sweep ends at once with `quality` = 1 and `p_out` set to that P.
- R6: A position whose centre passes but whose neighbour check fails becomes the backup. If no optimal position is found and a backup exists, the sweep ends after position 7 with `quality` = 2, `err` = 0 and `p_out` set to the last backup P.
- R7: If no centre trial passes, the sweep ends with `quality` = 0, `err` = 1 and `p_out` = `p_in`.
- R8: `pll_disable` goes high the cycle after `start` is accepted and falls in the same cycle that `done` pulses for one cycle. `pll_prog` is a one-cycle pulse while `pll_m`, `pll_n` and `pll_p` hold the trial values, and `pll_m` equals `m_in`.
- R9: Trial timers advance only on cycles where `tick` is high. With `tick` held low, no trial completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base strobe, one cycle per time unit |
| start | input | 1 | Begin a sweep (accepted when idle) |
| m_in | input | M_W | Reference divider value |
| n_in | input | N_W | Feedback divider value to qualify |
| p_in | input | P_W | Post-divider value with filter field |
| lock_in | input | 1 | Asynchronous PLL lock indication |
| pll_m | output | M_W | M value being applied |
| pll_n | output | N_W | N value being applied |
| pll_p | output | P_W | P value being applied |
| pll_prog | output | 1 | One-cycle strobe: load the applied values |
| pll_disable | output | 1 | Holds the PLL output disabled during a sweep |
| done | output | 1 | One-cycle pulse at the end of a sweep |
| p_out | output | P_W | Chosen P value |
| quality | output | 2 | 0 none, 1 optimal, 2 backup |
| err | output | 1 | No usable filter position was found |

## Verification
A plant model in the bench drives the lock input from the applied N and filter field. The model has four behaviours: steady lock, no lock, lock with three dropouts and lock with four dropouts. The last two sit on either side of the pass threshold, so they check the duty count exactly. Directed plants cover an all-good sweep (stop at the first position), an all-dead sweep (error fallback), a centre-only plant (backup at the last position) and a plant that fails only at N+3 (full neighbour order before a backup). A wrap case near N = 0 checks the modular neighbours, and a tick-starved case checks the time base. Random hashed plants then mix all four behaviours. Every applied setting is compared with the trial sequence that the bench predicts.

// File: rtl/pll_sweep_pkg.sv
package pll_sweep_pkg;

  typedef enum logic [2:0] {
    SW_IDLE,
    SW_LOAD,
    SW_ARM,
    SW_TRIAL,
    SW_FINISH
  } sweep_state_e;

  typedef enum logic [1:0] {
    TR_IDLE,
    TR_WAIT,
    TR_SAMPLE
  } trial_state_e;

  typedef enum logic [1:0] {
    QUAL_NONE    = 2'd0,
    QUAL_OPTIMAL = 2'd1,
    QUAL_BACKUP  = 2'd2
  } qual_e;

  // Number of neighbour trials that follow a passing centre trial
  localparam int NB_COUNT = 6;

  // Signed divider offset for trial slot idx (0 is the centre)
  function automatic int nb_delta(input int idx);
    case (idx)
      1:       return -3;
      2:       return -2;
      3:       return -1;
      4:       return 1;
      5:       return 2;
      6:       return 3;
      default: return 0;
    endcase
  endfunction

  // Duty qualification: enough locked samples in the window
  function automatic logic duty_ok(input int hits, input int need);
    return hits >= need;
  endfunction

  // Result selection at the end of a sweep
  function automatic logic [31:0] pick_result(input qual_e q, input logic [31:0] cur,
                                              input logic [31:0] backup,
                                              input logic [31:0] orig);
    case (q)
      QUAL_OPTIMAL: return cur;
      QUAL_BACKUP:  return backup;
      default:      return orig;
    endcase
  endfunction

endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pll_trial_engine.sv
module pll_trial_engine
  import pll_sweep_pkg::*;
#(
  parameter int WAIT_TICKS   = 1000,
  parameter int SAMPLE_TICKS = 1001,
  parameter int PASS_MIN     = 900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic go,
  input  logic lock_s,
  output logic busy,
  output logic trial_done,
  output logic trial_pass
);
  localparam int MAXT = (WAIT_TICKS > SAMPLE_TICKS) ? WAIT_TICKS : SAMPLE_TICKS;
  localparam int CW   = $clog2(MAXT + 1);
  localparam int HW   = $clog2(SAMPLE_TICKS + 1);

  trial_state_e    st;
  logic [CW-1:0]   cnt;
  logic [HW-1:0]   hits;
  logic [HW-1:0]   hits_next;
  logic            wait_last;
  logic            samp_last;

  assign hits_next = hits + HW'(lock_s);
  assign wait_last = (cnt == CW'(WAIT_TICKS - 1));
  assign samp_last = (cnt == CW'(SAMPLE_TICKS - 1));
  assign busy      = (st != TR_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= TR_IDLE;
      cnt        <= '0;
      hits       <= '0;
      trial_done <= 1'b0;
      trial_pass <= 1'b0;
    end else begin
      trial_done <= 1'b0;
      case (st)
        TR_IDLE: begin
          if (go) begin
            st   <= TR_WAIT;
            cnt  <= '0;
            hits <= '0;
          end
        end
        TR_WAIT: begin
          if (tick) begin
            if (lock_s) begin
              st   <= TR_SAMPLE;
              cnt  <= '0;
              hits <= '0;
            end else if (wait_last) begin
              st         <= TR_IDLE;
              trial_done <= 1'b1;
              trial_pass <= 1'b0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        TR_SAMPLE: begin
          if (tick) begin
            if (samp_last) begin
              st         <= TR_IDLE;
              trial_done <= 1'b1;
              trial_pass <= duty_ok(int'(hits_next), PASS_MIN);
            end else begin
              cnt  <= cnt + 1'b1;
              hits <= hits_next;
            end
          end
        end
        default: st <= TR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_sweep_ctrl.sv
module pll_sweep_ctrl
  import pll_sweep_pkg::*;
#(
  parameter int              M_W         = 8,
  parameter int              N_W         = 8,
  parameter int              P_W         = 8,
  parameter int              FILT_LSB    = 3,
  parameter int              FILT_STEPS  = 8,
  parameter logic [P_W-1:0]  KEEP_MASK   = 8'h47
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [M_W-1:0] m_in,
  input  logic [N_W-1:0] n_in,
  input  logic [P_W-1:0] p_in,
  input  logic           trial_done,
  input  logic           trial_pass,
  output logic           trial_go,
  output logic [M_W-1:0] pll_m,
  output logic [N_W-1:0] pll_n,
  output logic [P_W-1:0] pll_p,
  output logic           pll_prog,
  output logic           pll_disable,
  output logic           done,
  output logic [P_W-1:0] p_out,
  output logic [1:0]     quality,
  output logic           err
);
  localparam int FC_W = (FILT_STEPS > 1) ? $clog2(FILT_STEPS) : 1;
  localparam logic [P_W-1:0] FILT_STEP = P_W'(1 << FILT_LSB);

  sweep_state_e    st;
  logic [M_W-1:0]  m_r;
  logic [N_W-1:0]  n_r;
  logic [P_W-1:0]  p_orig;
  logic [P_W-1:0]  p_cur;
  logic [P_W-1:0]  p_backup;
  qual_e           q_r;
  logic [FC_W-1:0] filt;
  logic [2:0]      nb;
  logic            last_filt;
  logic            last_nb;
  logic [N_W-1:0]  n_trial;
  logic [P_W-1:0]  p_final;

  assign last_filt = (filt == FC_W'(FILT_STEPS - 1));
  assign last_nb   = (nb == 3'(NB_COUNT));
  assign n_trial   = n_r + N_W'(nb_delta(int'(nb)));
  assign p_final   = P_W'(pick_result(q_r, 32'(p_cur), 32'(p_backup), 32'(p_orig)));

  assign pll_prog  = (st == SW_ARM);
  assign trial_go  = (st == SW_ARM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= SW_IDLE;
      m_r         <= '0;
      n_r         <= '0;
      p_orig      <= '0;
      p_cur       <= '0;
      p_backup    <= '0;
      q_r         <= QUAL_NONE;
      filt        <= '0;
      nb          <= '0;
      pll_m       <= '0;
      pll_n       <= '0;
      pll_p       <= '0;
      pll_disable <= 1'b0;
      done        <= 1'b0;
      p_out       <= '0;
      quality     <= 2'd0;
      err         <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SW_IDLE: begin
          if (start) begin
            m_r         <= m_in;
            n_r         <= n_in;
            p_orig      <= p_in;
            p_cur       <= p_in & KEEP_MASK;
            p_backup    <= p_in;
            q_r         <= QUAL_NONE;
            filt        <= '0;
            nb          <= '0;
            pll_disable <= 1'b1;
            st          <= SW_LOAD;
          end
        end
        SW_LOAD: begin
          pll_m <= m_r;
          pll_n <= n_trial;
          pll_p <= p_cur;
          st    <= SW_ARM;
        end
        SW_ARM: begin
          st <= SW_TRIAL;
        end
        SW_TRIAL: begin
          if (trial_done) begin
            if (trial_pass) begin
              if (last_nb) begin
                q_r <= QUAL_OPTIMAL;
                st  <= SW_FINISH;
              end else begin
                nb <= nb + 3'd1;
                st <= SW_LOAD;
              end
            end else begin
              if (nb != 3'd0) begin
                p_backup <= p_cur;
                q_r      <= QUAL_BACKUP;
              end
              if (last_filt) begin
                st <= SW_FINISH;
              end else begin
                filt  <= filt + 1'b1;
                p_cur <= p_cur + FILT_STEP;
                nb    <= '0;
                st    <= SW_LOAD;
              end
            end
          end
        end
        SW_FINISH: begin
          p_out       <= p_final;
          quality     <= q_r;
          err         <= (q_r == QUAL_NONE);
          done        <= 1'b1;
          pll_disable <= 1'b0;
          st          <= SW_IDLE;
        end
        default: st <= SW_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_filter_sweep.sv
module pll_filter_sweep #(
  parameter int             M_W          = 8,
  parameter int             N_W          = 8,
  parameter int             P_W          = 8,
  parameter int             FILT_LSB     = 3,
  parameter int             FILT_STEPS   = 8,
  parameter logic [P_W-1:0] KEEP_MASK    = 8'h47,
  parameter int             WAIT_TICKS   = 1000,
  parameter int             SAMPLE_TICKS = 1001,
  parameter int             PASS_MIN     = 900,
  parameter int             SYNC_STAGES  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           start,
  input  logic [M_W-1:0] m_in,
  input  logic [N_W-1:0] n_in,
  input  logic [P_W-1:0] p_in,
  input  logic           lock_in,
  output logic [M_W-1:0] pll_m,
  output logic [N_W-1:0] pll_n,
  output logic [P_W-1:0] pll_p,
  output logic           pll_prog,
  output logic           pll_disable,
  output logic           done,
  output logic [P_W-1:0] p_out,
  output logic [1:0]     quality,
  output logic           err
);
  // Internal events, named for the checker
  logic lock_s;
  logic trial_go;
  logic trial_done;
  logic trial_pass;
  logic trial_busy;

  pll_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (lock_in),
    .q_sync  (lock_s)
  );

  pll_trial_engine #(
    .WAIT_TICKS   (WAIT_TICKS),
    .SAMPLE_TICKS (SAMPLE_TICKS),
    .PASS_MIN     (PASS_MIN)
  ) u_trial (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .go         (trial_go),
    .lock_s     (lock_s),
    .busy       (trial_busy),
    .trial_done (trial_done),
    .trial_pass (trial_pass)
  );

  pll_sweep_ctrl #(
    .M_W        (M_W),
    .N_W        (N_W),
    .P_W        (P_W),
    .FILT_LSB   (FILT_LSB),
    .FILT_STEPS (FILT_STEPS),
    .KEEP_MASK  (KEEP_MASK)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .m_in        (m_in),
    .n_in        (n_in),
    .p_in        (p_in),
    .trial_done  (trial_done),
    .trial_pass  (trial_pass),
    .trial_go    (trial_go),
    .pll_m       (pll_m),
    .pll_n       (pll_n),
    .pll_p       (pll_p),
    .pll_prog    (pll_prog),
    .pll_disable (pll_disable),
    .done        (done),
    .p_out       (p_out),
    .quality     (quality),
    .err         (err)
  );
endmodule

// File: rtl/pll_sweep_checker.sv
module pll_sweep_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       pll_prog,
  input logic       pll_disable,
  input logic       done,
  input logic       err,
  input logic [1:0] quality,
  input logic       trial_go,
  input logic       trial_done,
  input logic       trial_busy
);
  // R8: settings are only loaded while the PLL is held off
  p_prog_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pll_prog |-> pll_disable);

  // R8: programming strobe lasts a single cycle
  p_prog_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pll_prog |=> !pll_prog);

  // R8: PLL released together with completion
  p_done_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pll_disable);

  // R7: error flag tracks the empty-result code
  p_err_matches_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err == (quality == 2'd0)));

  // R5: only three result codes exist
  p_quality_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    quality != 2'd3);

  // R9: a trial cannot end on a cycle without a tick
  p_tick_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !trial_go) |=> !trial_done);

  // R2: a new trial never starts while one is running
  p_go_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trial_go |-> !trial_busy);
endmodule

bind pll_filter_sweep pll_sweep_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .pll_prog    (pll_prog),
  .pll_disable (pll_disable),
  .done        (done),
  .err         (err),
  .quality     (quality),
  .trial_go    (trial_go),
  .trial_done  (trial_done),
  .trial_busy  (trial_busy)
);

// File: tb/pll_filter_sweep_bench.sv
module pll_filter_sweep_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_T     = 16;
  localparam int SAMPLE_T   = 21;
  localparam int PASS_T     = 18;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       start = 1'b0;
  logic [7:0] m_in = '0, n_in = '0, p_in = '0;
  logic       lock_in = 1'b0;
  logic [7:0] pll_m, pll_n, pll_p, p_out;
  logic       pll_prog, pll_disable, done, err;
  logic [1:0] quality;

  pll_filter_sweep #(
    .WAIT_TICKS(WAIT_T), .SAMPLE_TICKS(SAMPLE_T), .PASS_MIN(PASS_T)
  ) u_pll_filter_sweep (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
    .m_in(m_in), .n_in(n_in), .p_in(p_in), .lock_in(lock_in),
    .pll_m(pll_m), .pll_n(pll_n), .pll_p(pll_p), .pll_prog(pll_prog),
    .pll_disable(pll_disable), .done(done), .p_out(p_out),
    .quality(quality), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Plant model. Kinds: 0 steady lock, 1 no lock, 2 three dropouts, 3 four dropouts
  int         mode = 0;
  int         cseed = 0;
  logic [7:0] centre = '0;
  int         cur_kind = 1;
  int         cyc = 0;

  function automatic int kind_of(input logic [7:0] n, input logic [7:0] p);
    int f, h;
    f = int'((p >> 3) & 8'h07);
    case (mode)
      1: return 0;
      2: return 1;
      3: return (n == centre) ? 0 : 1;
      4: return (n == 8'(centre + 8'd3)) ? 3 : 0;
      5: return 2;
      6: return 3;
      default: begin
        h = ((int'(n) * 37 + f * 101 + cseed * 13) ^ (int'(n) >> 2)) % 8;
        if (h <= 4) return 0;
        if (h == 5) return 2;
        if (h == 6) return 1;
        return 3;
      end
    endcase
  endfunction

  function automatic bit kind_ok(input int k);
    return (k == 0) || (k == 2);
  endfunction

  function automatic logic lock_level(input int k, input int c);
    case (k)
      0: return 1'b1;
      2: return !(c >= 8 && c < 11);
      3: return !(c >= 8 && c < 12);
      default: return 1'b0;
    endcase
  endfunction

  // Expected trial sequence and result
  logic [7:0] exp_n [0:63];
  logic [7:0] exp_p [0:63];
  int         exp_cnt;
  logic [7:0] exp_res;
  int         exp_q;
  logic [7:0] cur_m;
  int         prog_seen = 0;
  bit         monitor_on = 0;

  function automatic int offs(input int j);
    case (j)
      0: return -3; 1: return -2; 2: return -1;
      3: return 1;  4: return 2;  default: return 3;
    endcase
  endfunction

  task automatic build_expect(input logic [7:0] n, input logic [7:0] p);
    logic [7:0] p0, pf, bk, nn;
    bit all_good;
    exp_cnt = 0; exp_q = 0; bk = p; p0 = p & 8'h47; exp_res = p;
    for (int s = 0; s < 8; s++) begin
      pf = p0 + 8'(8 * s);
      exp_n[exp_cnt] = n; exp_p[exp_cnt] = pf; exp_cnt++;
      if (kind_ok(kind_of(n, pf))) begin
        all_good = 1;
        for (int j = 0; j < 6; j++) begin
          nn = 8'(int'(n) + offs(j));
          exp_n[exp_cnt] = nn; exp_p[exp_cnt] = pf; exp_cnt++;
          if (!kind_ok(kind_of(nn, pf))) begin all_good = 0; break; end
        end
        if (all_good) begin exp_q = 1; exp_res = pf; break; end
        exp_q = 2; bk = pf;
      end
    end
    if (exp_q == 2) exp_res = bk;
  endtask

  always @(negedge clk) begin
    if (pll_prog) begin
      if (monitor_on) begin
        if (prog_seen < exp_cnt) begin
          check(pll_n == exp_n[prog_seen], "R5 trial N", int'(pll_n), int'(exp_n[prog_seen]));
          check(pll_p == exp_p[prog_seen], "R4 trial P", int'(pll_p), int'(exp_p[prog_seen]));
        end else begin
          check(1'b0, "R5 extra trial", prog_seen, exp_cnt);
        end
        check(pll_m == cur_m && pll_disable, "R8 applied M / disable", int'(pll_m), int'(cur_m));
      end
      prog_seen++;
      cur_kind = kind_of(pll_n, pll_p);
      cyc = 0;
    end else begin
      cyc++;
    end
    lock_in = lock_level(cur_kind, cyc);
  end

  task automatic launch(input logic [7:0] m, input logic [7:0] n, input logic [7:0] p);
    cur_m = m; build_expect(n, p); prog_seen = 0; monitor_on = 1;
    m_in = m; n_in = n; p_in = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(pll_disable == 1'b1, "R8 disable raised", int'(pll_disable), 1);
  endtask

  task automatic finish_case(input logic [7:0] p, input string tag);
    int guard = 0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    check(done == 1'b1, {tag, " R8 done pulse"}, int'(done), 1);
    check(pll_disable == 1'b0, {tag, " R8 disable released"}, int'(pll_disable), 0);
    check(prog_seen == exp_cnt, {tag, " R5 trial count"}, prog_seen, exp_cnt);
    check(quality == 2'(exp_q), {tag, " R6 quality"}, int'(quality), exp_q);
    check(p_out == exp_res, {tag, " R7 p_out"}, int'(p_out), int'(exp_res));
    check(err == (exp_q == 0), {tag, " R7 err"}, int'(err), int'(exp_q == 0));
    @(negedge clk);
    check(done == 1'b0, {tag, " R8 done one cycle"}, int'(done), 0);
    monitor_on = 0;
    if (p == 8'h00) ; // no-op keeps argument used
  endtask

  task automatic run_case(input logic [7:0] m, input logic [7:0] n, input logic [7:0] p,
                          input string tag);
    launch(m, n, p);
    finish_case(p, tag);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2917));
    repeat (3) @(negedge clk);
    // R1 reset state
    check({done, pll_prog, pll_disable, err} == 4'b0, "R1 control outputs",
          int'({done, pll_prog, pll_disable, err}), 0);
    check(quality == 2'd0 && p_out == 8'h00, "R1 result outputs", int'({quality, p_out}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5 all good: stops at first position (p bits 5:3 and 7 masked, R4)
    mode = 1; run_case(8'h11, 8'd60, 8'hBF, "allgood");
    // R2 / R7 never locks: error fallback to original P
    mode = 2; run_case(8'h05, 8'd90, 8'hFA, "dead");
    // R6 centre only: backup is the last position
    mode = 3; centre = 8'd40; run_case(8'h07, 8'd40, 8'h41, "centre");
    // R5 / R6 only N+3 fails: full neighbour order each position
    mode = 4; centre = 8'd77; run_case(8'h02, 8'd77, 8'h03, "nplus3");
    // R3 three dropouts pass the threshold
    mode = 5; run_case(8'h09, 8'd20, 8'h00, "thr_pass");
    // R3 four dropouts fail it
    mode = 6; run_case(8'h09, 8'd20, 8'h00, "thr_fail");
    // R5 modular neighbours around zero
    mode = 1; run_case(8'h03, 8'd1, 8'h47, "wrap");

    // R9 tick starved: no trial may complete
    mode = 1; tick = 1'b0;
    launch(8'h0A, 8'd100, 8'h12);
    repeat (60) @(negedge clk);
    check(done == 1'b0, "R9 no done without ticks", int'(done), 0);
    check(prog_seen == 1, "R9 single trial pending", prog_seen, 1);
    tick = 1'b1;
    finish_case(8'h12, "tick");
    repeat (3) @(negedge clk);

    // Random hashed plants
    mode = 0;
    for (int i = 0; i < 30; i++) begin
      cseed = i;
      run_case(8'($urandom), 8'(3 + ($urandom % 250)), 8'($urandom), "rand");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule